// File: doc/BRIEF.md
# Two-Wire Debug Port Transfer Engine

This block runs one complete register access on a two-wire serial debug link, acting as the host. A caller presents a 4-bit request and a write word, then pulses `start`. The engine builds the 8-bit header with its parity bit and shifts it out. It hands the data line to the target for a programmable turnaround and reads back a 3-bit acknowledge. What happens next depends on that acknowledge. On OK, it moves a 32-bit word plus parity in the requested direction and then clocks idle cycles. On WAIT or FAULT, it clocks turnaround and, optionally, a 33-cycle dummy data phase. On any other code it backs off with the line released. When the transfer ends, the line is left high and `done` rises.

The caller sees a simple start/done handshake. At `start` the engine latches the request, the write word and all configuration inputs, so the caller may change them during the transfer. The status code and the read word stay valid on the outputs until the next `start`. The serial clock rate comes from a divider that sets the length of each half period in system clocks. Retrying after WAIT and parsing higher-level commands belong to the caller.

Top module: `swd_xfer_engine`

## Requirements
- R1: The header is sent least-significant bit first as the byte {1, 0, P, req[3:0], 1}, where bit 0 is the start bit, bits 4..1 carry req, bit 5 is P (the even parity of req), bit 6 is 0 and bit 7 is 1. req[0] selects access/debug port, req[1] is the read flag (1 = read) and req[3:2] are address bits.
- R2: After the header, the line is released (`swdio_oe`=0) for turn_cfg+1 bit slots. Then three released slots capture the acknowledge, least-significant bit first. OK=1, WAIT=2, FAULT=4.
- R3: On a read with acknowledge OK, the engine captures 32 data bits least-significant bit first and then a parity bit, with the line released. It then keeps the line released for another turnaround. The data appear on `rdata`. After any transfer other than an OK read, `rdata` is 0.
- R4: On an OK read whose received parity differs from the even parity of the 32 data bits, `status` is 8. Otherwise `status` is {0, ack}.
- R5: On a write with acknowledge OK, a released turnaround comes first. Then the host drives the 32 latched data bits least-significant bit first, followed by their even parity.
- R6: After an OK transfer, the engine clocks idle_len slots with the line driven low. When a transfer ends, `swclk`, `swdio_oe` and `swdio_o` are all 1.
- R7: On WAIT or FAULT with `data_pad_en`=1, a read clocks 33 released slots and then a turnaround. A write clocks a turnaround and then 33 slots driven low. With `data_pad_en`=0, only the turnaround follows.
- R8: Any other acknowledge (0, 3, 5, 6, 7) is followed by turn_cfg+1+33 released slots. `status` is {0, ack}.
- R9: Every bit slot begins with `swclk` falling and the new line value applied. The input is sampled on the edge where `swclk` rises. Each half period lasts `half_len` system clocks, and a value of 0 counts as 1.
- R10: `start` while idle latches request, write word and configuration, and sets `busy` and clears `done` on the next clock. `done`, `status` and `rdata` then stay constant until the next `start`.
- R11: After reset, `busy` and `done` are 0 and `swclk`, `swdio_oe` and `swdio_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted while idle) |
| xfer_req | input | 4 | Port select, read flag, two address bits |
| xfer_wdata | input | DATA_W | Word to write |
| turn_cfg | input | TURN_W | Turnaround length minus one |
| idle_len | input | IDLE_W | Idle slots after an OK transfer |
| data_pad_en | input | 1 | Dummy data phase on WAIT/FAULT |
| half_len | input | DIV_W | Half period of the serial clock in system clocks |
| swdio_i | input | 1 | Data line as seen at the pin |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data line drive value |
| swdio_oe | output | 1 | Data line drive enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Result valid, held until next start |
| status | output | 4 | Acknowledge, or 8 on read parity error |
| rdata | output | DATA_W | Word read |

## Verification
The assertions check the handshake and line rules on every cycle. The line must be parked high while idle. Results must hold while `done` is up. An accepted `start` must launch the clock. Drive value and enable must not move during the low half of a slot. The exact slot sequence can only be shown by the bench's scenarios, which play the target side: header bits, turnaround lengths, dummy phases, back-off length, parity handling and half-period timing. The bench compares every rising clock edge against an expected slot list that it builds from the requirements.

// File: rtl/swd_xfer_pkg.sv
`timescale 1ns/1ps
package swd_xfer_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_TRN_A,
        ST_ACK,
        ST_RD_DATA,
        ST_TRN_B,
        ST_WR_DATA,
        ST_IDLE_CYC,
        ST_PAD_REL,
        ST_PAD_LOW
    } seq_state_t;

    typedef struct packed {
        logic [1:0] addr;
        logic       rnw;
        logic       port_sel;
    } swd_req_t;

    localparam logic [2:0] ACK_OK    = 3'd1;
    localparam logic [2:0] ACK_WAIT  = 3'd2;
    localparam logic [2:0] ACK_FAULT = 3'd4;
    localparam logic [3:0] STAT_PARITY_ERR = 4'h8;
    localparam int unsigned HDR_BITS = 8;
    localparam int unsigned ACK_BITS = 3;

    function automatic logic [7:0] build_header(input swd_req_t r);
        return {1'b1, 1'b0, ^r, r, 1'b1};
    endfunction

endpackage

// File: rtl/swd_half_div.sv
`timescale 1ns/1ps
module swd_half_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] half_len,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = (half_len == '0) ? '0 : half_len - DIV_W'(1);
        tick = (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/swd_seq_fsm.sv
`timescale 1ns/1ps
module swd_seq_fsm
    import swd_xfer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TURN_W = 2,
    parameter int unsigned IDLE_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        req_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [TURN_W-1:0] turn_in,
    input  logic [IDLE_W-1:0] idle_in,
    input  logic              pad_in,
    input  logic [DIV_W-1:0]  half_in,
    input  logic              tick,
    input  logic              din,
    output logic              restart,
    output logic [DIV_W-1:0]  half_q,
    output logic              swclk,
    output logic              dout,
    output logic              doe,
    output logic              busy,
    output logic              done,
    output logic [3:0]        status,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DW_BITS = $clog2(DATA_W + 1);
    localparam int unsigned CNT_W   = (IDLE_W > DW_BITS) ? IDLE_W : DW_BITS;
    localparam int unsigned IDX_W   = $clog2(DATA_W);

    seq_state_t        st, nxt;
    logic [CNT_W-1:0]  cnt;
    logic              phase;
    swd_req_t          req_q;
    logic [DATA_W-1:0] wd_q, rd_q, wsh;
    logic [TURN_W-1:0] turn_q;
    logic [IDLE_W-1:0] idle_q;
    logic              pad_q, rpar_q;
    logic [2:0]        ack_q;
    logic [7:0]        hdr;
    logic              slot_last, ack_ok, ack_wf;

    always_comb begin
        hdr    = build_header(req_q);
        wsh    = wd_q >> cnt;
        ack_ok = (ack_q == ACK_OK);
        ack_wf = (ack_q == ACK_WAIT) || (ack_q == ACK_FAULT);
        unique case (st)
            ST_HDR:                 slot_last = (cnt == CNT_W'(HDR_BITS - 1));
            ST_TRN_A, ST_TRN_B:     slot_last = (cnt == CNT_W'(turn_q));
            ST_ACK:                 slot_last = (cnt == CNT_W'(ACK_BITS - 1));
            ST_IDLE_CYC:            slot_last = (cnt == CNT_W'(idle_q) - CNT_W'(1));
            ST_IDLE:                slot_last = 1'b0;
            default:                slot_last = (cnt == CNT_W'(DATA_W));
        endcase
        unique case (st)
            ST_IDLE:                begin doe = 1'b1; dout = 1'b1; end
            ST_HDR:                 begin doe = 1'b1; dout = hdr[cnt[2:0]]; end
            ST_WR_DATA:             begin doe = 1'b1; dout = (cnt == CNT_W'(DATA_W)) ? ^wd_q : wsh[0]; end
            ST_IDLE_CYC, ST_PAD_LOW: begin doe = 1'b1; dout = 1'b0; end
            default:                begin doe = 1'b0; dout = 1'b1; end
        endcase
        unique case (st)
            ST_HDR:     nxt = ST_TRN_A;
            ST_TRN_A:   nxt = ST_ACK;
            ST_ACK:     nxt = ack_ok ? (req_q.rnw ? ST_RD_DATA : ST_TRN_B)
                            : ack_wf ? ((pad_q && req_q.rnw) ? ST_PAD_REL : ST_TRN_B)
                            : ST_PAD_REL;
            ST_RD_DATA: nxt = ST_TRN_B;
            ST_PAD_REL: nxt = ST_TRN_B;
            ST_TRN_B:   nxt = (ack_ok && !req_q.rnw) ? ST_WR_DATA
                            : (ack_ok && idle_q != '0) ? ST_IDLE_CYC
                            : (ack_wf && pad_q && !req_q.rnw) ? ST_PAD_LOW
                            : ST_IDLE;
            ST_WR_DATA: nxt = (idle_q != '0) ? ST_IDLE_CYC : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    assign restart = (st == ST_IDLE) && start;
    assign busy    = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            phase  <= 1'b0;
            req_q  <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
            turn_q <= '0;
            idle_q <= '0;
            pad_q  <= 1'b0;
            half_q <= '0;
            rpar_q <= 1'b0;
            ack_q  <= '0;
            swclk  <= 1'b1;
            done   <= 1'b0;
            status <= '0;
        end else if (st == ST_IDLE) begin
            if (start) begin
                st     <= ST_HDR;
                cnt    <= '0;
                phase  <= 1'b0;
                req_q  <= swd_req_t'(req_in);
                wd_q   <= wdata_in;
                turn_q <= turn_in;
                idle_q <= idle_in;
                pad_q  <= pad_in;
                half_q <= half_in;
                rd_q   <= '0;
                ack_q  <= '0;
                swclk  <= 1'b0;
                done   <= 1'b0;
            end
        end else if (tick) begin
            if (!phase) begin
                if (st == ST_ACK) ack_q[cnt[1:0]] <= din;
                if (st == ST_RD_DATA) begin
                    if (cnt < CNT_W'(DATA_W)) rd_q[cnt[IDX_W-1:0]] <= din;
                    else                      rpar_q <= din;
                end
                swclk <= 1'b1;
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                if (slot_last) begin
                    cnt <= '0;
                    st  <= nxt;
                    if (nxt == ST_IDLE) begin
                        done   <= 1'b1;
                        status <= (ack_ok && req_q.rnw && ((^rd_q) != rpar_q))
                                  ? STAT_PARITY_ERR : {1'b0, ack_q};
                    end else begin
                        swclk <= 1'b0;
                    end
                end else begin
                    cnt   <= cnt + CNT_W'(1);
                    swclk <= 1'b0;
                end
            end
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/swd_xfer_engine.sv
`timescale 1ns/1ps
module swd_xfer_engine #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TURN_W = 2,
    parameter int unsigned IDLE_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        xfer_req,
    input  logic [DATA_W-1:0] xfer_wdata,
    input  logic [TURN_W-1:0] turn_cfg,
    input  logic [IDLE_W-1:0] idle_len,
    input  logic              data_pad_en,
    input  logic [DIV_W-1:0]  half_len,
    input  logic              swdio_i,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe,
    output logic              busy,
    output logic              done,
    output logic [3:0]        status,
    output logic [DATA_W-1:0] rdata
);
    logic             tick, restart;
    logic [DIV_W-1:0] half_q;

    swd_half_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .half_len (half_q),
        .tick     (tick)
    );

    swd_seq_fsm #(
        .DATA_W (DATA_W),
        .TURN_W (TURN_W),
        .IDLE_W (IDLE_W),
        .DIV_W  (DIV_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req_in   (xfer_req),
        .wdata_in (xfer_wdata),
        .turn_in  (turn_cfg),
        .idle_in  (idle_len),
        .pad_in   (data_pad_en),
        .half_in  (half_len),
        .tick     (tick),
        .din      (swdio_i),
        .restart  (restart),
        .half_q   (half_q),
        .swclk    (swclk),
        .dout     (swdio_o),
        .doe      (swdio_oe),
        .busy     (busy),
        .done     (done),
        .status   (status),
        .rdata    (rdata)
    );
endmodule

// File: rtl/swd_xfer_chk.sv
`timescale 1ns/1ps
module swd_xfer_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              swclk,
    input logic              swdio_o,
    input logic              swdio_oe,
    input logic              busy,
    input logic              done,
    input logic [3:0]        status,
    input logic [DATA_W-1:0] rdata
);
    // R6, R11: line parked high whenever no transfer runs
    p_idle_line_high_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (swclk && swdio_oe && swdio_o));

    // R10: done and busy never both set
    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10: results held until a new start
    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(status) && $stable(rdata)));

    // R10, R9: accepted start launches the first slot with a falling clock
    p_start_launch_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && !swclk));

    // R9: drive value and enable stay fixed within a low half period
    p_low_half_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !swclk && $past(busy) && $past(!swclk))
        |-> ($stable(swdio_o) && $stable(swdio_oe)));
endmodule

bind swd_xfer_engine swd_xfer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .swclk    (swclk),
    .swdio_o  (swdio_o),
    .swdio_oe (swdio_oe),
    .busy     (busy),
    .done     (done),
    .status   (status),
    .rdata    (rdata)
);

// File: tb/test_swd_xfer_engine.sv
`timescale 1ns/1ps
module test_swd_xfer_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  xfer_req = '0;
    logic [31:0] xfer_wdata = '0;
    logic [1:0]  turn_cfg = '0;
    logic [7:0]  idle_len = '0;
    logic        data_pad_en = 1'b0;
    logic [7:0]  half_len = 8'd1;
    logic        swdio_i = 1'b1;
    logic        swclk, swdio_o, swdio_oe, busy, done;
    logic [3:0]  status;
    logic [31:0] rdata;

    always #4 clk = ~clk;

    swd_xfer_engine i_swd_xfer_engine (
        .clk(clk), .rst(rst), .start(start), .xfer_req(xfer_req),
        .xfer_wdata(xfer_wdata), .turn_cfg(turn_cfg), .idle_len(idle_len),
        .data_pad_en(data_pad_en), .half_len(half_len), .swdio_i(swdio_i),
        .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .busy(busy),
        .done(done), .status(status), .rdata(rdata)
    );

    typedef struct {
        logic [3:0]  st;
        logic [31:0] rd;
        int          nbits;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    int checks = 0;
    int fails  = 0;
    logic ex_oe [0:255];
    logic ex_o  [0:255];
    logic tgt   [0:255];
    int   ex_len = 0;
    int   half_cur = 1;
    int   bitidx = -1;
    int   lowcnt = 0;
    int   wave_err = 0;
    string wave_msg = "";
    logic clk_prev = 1'b1;
    logic done_prev = 1'b0;

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic void put(input logic oe, input logic o, input logic t);
        ex_oe[ex_len] = oe;
        ex_o[ex_len]  = o;
        tgt[ex_len]   = t;
        ex_len++;
    endfunction

    // Monitor: plays the target and compares against the scoreboard
    always @(negedge clk) begin
        if (rst) begin
            clk_prev  = 1'b1;
            done_prev = 1'b0;
            bitidx    = -1;
        end else begin
            if (start) begin
                bitidx   = -1;
                wave_err = 0;
                wave_msg = "";
            end
            if (clk_prev && !swclk) begin
                bitidx++;
                lowcnt = 0;
                if (bitidx >= 0 && bitidx < 256) swdio_i = tgt[bitidx];
            end
            if (!swclk) lowcnt++;
            if (!clk_prev && swclk && busy) begin
                if (bitidx >= ex_len) begin
                    if (wave_err == 0) wave_msg = $sformatf("extra slot %0d", bitidx);
                    wave_err++;
                end else if (ex_oe[bitidx] !== swdio_oe || (ex_oe[bitidx] && ex_o[bitidx] !== swdio_o)) begin
                    if (wave_err == 0)
                        wave_msg = $sformatf("slot %0d oe/o act=%b%b exp=%b%b", bitidx,
                                             swdio_oe, swdio_o, ex_oe[bitidx], ex_o[bitidx]);
                    wave_err++;
                end else if (lowcnt != half_cur) begin
                    if (wave_err == 0)
                        wave_msg = $sformatf("R9 slot %0d low half act=%0d exp=%0d", bitidx, lowcnt, half_cur);
                    wave_err++;
                end
            end
            if (done && !done_prev) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R10 done with no pending transfer act=1 exp=0");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(wave_err == 0, $sformatf("R1 R2 %s waveform: %s act_errs=%0d exp=0",
                                                 e.tag, wave_msg, wave_err));
                    chk(bitidx + 1 == e.nbits, $sformatf("%s slot count act=%0d exp=%0d",
                                                         e.tag, bitidx + 1, e.nbits));
                    chk(status == e.st, $sformatf("R4 %s status act=%0d exp=%0d", e.tag, status, e.st));
                    chk(rdata == e.rd, $sformatf("R3 %s rdata act=%h exp=%h", e.tag, rdata, e.rd));
                    chk(swclk && swdio_oe && swdio_o,
                        $sformatf("R6 %s end line clk/oe/o act=%b%b%b exp=111", e.tag, swclk, swdio_oe, swdio_o));
                end
            end
            clk_prev  = swclk;
            done_prev = done;
        end
    end

    // Driver: builds the expected slot list from the requirements and launches
    task automatic xfer(input string tag, input logic [3:0] req, input logic [31:0] wd,
                        input logic [2:0] ackr, input logic [31:0] rdr, input bit badpar,
                        input int turn, input int idle, input bit pad, input int half);
        logic [7:0] pkt;
        logic       rnw;
        exp_t       e;
        pkt    = {1'b1, 1'b0, ^req, req, 1'b1};
        rnw    = req[1];
        ex_len = 0;
        for (int i = 0; i < 8; i++) put(1'b1, pkt[i], 1'b1);
        for (int i = 0; i < turn; i++) put(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) put(1'b0, 1'b0, ackr[i]);
        if (ackr == 3'd1) begin
            if (rnw) begin
                for (int i = 0; i < 32; i++) put(1'b0, 1'b0, rdr[i]);
                put(1'b0, 1'b0, (^rdr) ^ badpar);
                for (int i = 0; i < turn; i++) put(1'b0, 1'b0, 1'b1);
            end else begin
                for (int i = 0; i < turn; i++) put(1'b0, 1'b0, 1'b1);
                for (int i = 0; i < 32; i++) put(1'b1, wd[i], 1'b1);
                put(1'b1, ^wd, 1'b1);
            end
            for (int i = 0; i < idle; i++) put(1'b1, 1'b0, 1'b1);
        end else if (ackr == 3'd2 || ackr == 3'd4) begin
            if (pad && rnw) for (int i = 0; i < 33; i++) put(1'b0, 1'b0, 1'b1);
            for (int i = 0; i < turn; i++) put(1'b0, 1'b0, 1'b1);
            if (pad && !rnw) for (int i = 0; i < 33; i++) put(1'b1, 1'b0, 1'b1);
        end else begin
            for (int i = 0; i < turn + 33; i++) put(1'b0, 1'b0, 1'b1);
        end
        e.st    = (ackr == 3'd1 && rnw && badpar) ? 4'h8 : {1'b0, ackr};
        e.rd    = (ackr == 3'd1 && rnw) ? rdr : 32'h0;
        e.nbits = ex_len;
        e.tag   = tag;
        sb_q.push_back(e);
        half_cur = (half == 0) ? 1 : half;
        @(posedge clk); #1;
        xfer_req    = req;
        xfer_wdata  = wd;
        turn_cfg    = 2'(turn - 1);
        idle_len    = 8'(idle);
        data_pad_en = pad;
        half_len    = 8'(half);
        start       = 1'b1;
        @(posedge clk); #1;
        start      = 1'b0;
        xfer_req   = ~req;
        xfer_wdata = ~wd;
        turn_cfg   = ~turn_cfg;
        idle_len   = idle_len + 8'd5;
        half_len   = half_len + 8'd2;
        data_pad_en = ~pad;
        while (!done) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        chk(done && status == e.st, $sformatf("R10 %s result held act=%b/%0d exp=1/%0d",
                                               tag, done, status, e.st));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, $sformatf("R11 busy/done act=%b%b exp=00", busy, done));
        chk(swclk && swdio_oe && swdio_o,
            $sformatf("R11 clk/oe/o act=%b%b%b exp=111", swclk, swdio_oe, swdio_o));

        xfer("R3 ok read",          4'b0010, 32'h0,         3'd1, 32'hA5C3_1E97, 1'b0, 1, 0, 1'b0, 1);
        xfer("R5 R6 ok write",      4'b0100, 32'h1234_5679, 3'd1, 32'h0,         1'b0, 1, 3, 1'b0, 2);
        xfer("R4 parity error",     4'b1011, 32'h0,         3'd1, 32'h0F0F_3C3D, 1'b1, 1, 0, 1'b0, 1);
        xfer("R7 wait read pad",    4'b0110, 32'h0,         3'd2, 32'hFFFF_FFFF, 1'b0, 2, 4, 1'b1, 1);
        xfer("R7 fault write pad",  4'b1001, 32'hDEAD_BEEF, 3'd4, 32'h0,         1'b0, 1, 2, 1'b1, 1);
        xfer("R7 wait read nopad",  4'b0011, 32'h0,         3'd2, 32'h0,         1'b0, 3, 1, 1'b0, 1);
        xfer("R7 wait write nopad", 4'b1100, 32'h8000_0001, 3'd2, 32'h0,         1'b0, 1, 1, 1'b0, 2);
        xfer("R8 bad ack 7 read",   4'b0010, 32'h0,         3'd7, 32'h0,         1'b0, 2, 3, 1'b1, 1);
        xfer("R8 bad ack 0 write",  4'b0000, 32'h5555_AAAA, 3'd0, 32'h0,         1'b0, 4, 3, 1'b0, 1);
        xfer("R2 R3 R6 long turn",  4'b1111, 32'h0,         3'd1, 32'h7E81_0246, 1'b0, 4, 2, 1'b0, 3);
        xfer("R9 half zero write",  4'b1000, 32'hC001_D00D, 3'd1, 32'h0,         1'b0, 1, 1, 1'b0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule